// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management transactions to an external PHY. Software sees four word registers on a simple single-cycle bus: a configuration word, a control word, a write-data word and a read-data word. It programs a clock divisor and sets the enable bit. For a write it loads the 16-bit value first. It then writes the control word with the PHY address, register address, opcode and start bit, and polls the ready bit until the transaction has finished.

The management clock is made from the host clock by a programmable divider and runs only while a frame is in flight. The sequencer shifts out a complete 64-bit frame. Outgoing bits change on the falling edge of the management clock. On reads, the block releases the data line for the turnaround and data phases and captures the PHY's bits on rising edges. After the last data bit, one idle clock period passes before ready returns.

Top module: `mdio_master`

## Requirements
- R1: The management clock has a period of 2*(div+1) host cycles, high and low for div+1 cycles each. div is bits [7:0] of the configuration word (offset 0). The clock is held low whenever no frame is in flight.
- R2: The enable bit is bit 8 of the configuration word. While it is 0, a start request is ignored. Clearing it during a frame ends the frame: from the next cycle the clock is low, the output enable is low and ready reads 1.
- R3: The control word (offset 1) reads back the last accepted fields: register address in bits [4:0], PHY address in [9:5], opcode in bit 10 (1 = read, 0 = write), and ready in bit 15. Writing 1 to bit 11 requests a start; bit 11 reads 0.
- R4: A frame is made of 32 ones, start code 01, opcode 10 (read) or 01 (write), the PHY address MSB first, the register address MSB first, two turnaround bits and 16 data bits MSB first. The data line changes only on falling clock edges.
- R5: A write sends bits [15:0] of the write-data word (offset 2) and drives the turnaround as 10. Output enable is high at every one of the 64 rising edges.
- R6: On a read, output enable is low from the first turnaround bit to the end of the frame. Bits are sampled from the input on rising clock edges. Once ready returns to 1, they sit in bits [15:0] of the read-data word (offset 3).
- R7: Ready reads 0 starting on the cycle after an accepted start. It stays 0 for exactly 130*(div+1) host cycles: 64 bit periods plus one idle period.
- R8: A control write made while ready reads 0 is ignored entirely, both the start and the fields. This includes a write in the cycle whose edge ends the frame.
- R9: The read-data word resets to 0 and changes only when a read completes. A write transaction leaves it unchanged.
- R10: After reset the enable bit is 0, ready is 1, the clock is low, the output enable is low and all stored fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected word (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A new start request can land in the same cycle as the edge that ends a frame. Ready still reads 0 during that cycle, so the request must be dropped. The bench counts host cycles from an accepted start to the completing edge and places a control write with a different address, opcode and start exactly on that edge. It then judges the outcome by three things: ready reads 1 on the next cycle, the control word still shows the fields of the finished frame, and the clock stays low afterwards. A second collision, a disable write taking effect mid-frame, is judged by clock, enable and ready on the following cycle.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_WDATA = 2'd2;
  localparam logic [1:0] ADDR_RDATA = 2'd3;

  localparam int CFG_EN_BIT    = 8;
  localparam int CTRL_OP_BIT   = 10;
  localparam int CTRL_GO_BIT   = 11;
  localparam int CTRL_RDY_BIT  = 15;
  localparam int FIELD_W       = 5;
  localparam int DATA_W        = 16;

  localparam int PRE_BITS      = 32;
  localparam int FRAME_BITS    = 64;
  localparam int TA_POS        = 46;
  localparam int DATA_POS      = 48;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  op_e                op_i,
  input  logic [FIELD_W-1:0] phy_i,
  input  logic [FIELD_W-1:0] reg_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] TA_C = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DA_C = CNT_W'(DATA_POS);

  logic [FRAME_BITS-1:0] frame, sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  busy_q, rd_q, valid_q;
  logic [DATA_W-1:0]     cap_q;
  logic                  in_frame;

  always_comb begin
    frame = {{PRE_BITS{1'b1}}, 2'b01,
             (op_i == OP_READ) ? 2'b10 : 2'b01,
             phy_i, reg_i,
             (op_i == OP_READ) ? 2'b11 : 2'b10,
             (op_i == OP_READ) ? {DATA_W{1'b1}} : wdata_i};
  end

  assign in_frame   = busy_q && (cnt_q < LAST);
  assign mdio_o     = !in_frame || sh_q[FRAME_BITS-1];
  assign mdio_oe_o  = in_frame && !(rd_q && cnt_q >= TA_C);
  assign busy_o     = busy_q;
  assign rd_valid_o = valid_q;
  assign rd_data_o  = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      cap_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= (op_i == OP_READ);
        cnt_q  <= '0;
        sh_q   <= frame;
      end else if (busy_q) begin
        if (abort_i) begin
          busy_q <= 1'b0;
        end else begin
          if (rise_i && rd_q && cnt_q >= DA_C && cnt_q < LAST)
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
          if (fall_i) begin
            if (cnt_q == LAST) begin
              busy_q  <= 1'b0;
              valid_q <= rd_q;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
          end
        end
      end
    end
  end

  // R4: outgoing bit changes only with a falling clock strobe
  a_r4_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $past(fall_i));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [DIV_W-1:0]   div_q;
  logic               en_q;
  logic [FIELD_W-1:0] phy_q, reg_q;
  op_e                op_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               busy, ready, ctrl_wr, start_acc;
  logic               rise, fall, rd_valid;
  logic [DATA_W-1:0]  rd_data;
  op_e                op_in;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign ready     = !busy;
  assign ctrl_wr   = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign start_acc = ctrl_wr && reg_wdata_i[CTRL_GO_BIT] && ready && en_q;
  assign op_in     = op_e'(reg_wdata_i[CTRL_OP_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      en_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      op_q    <= OP_WRITE;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_CFG) begin
        div_q <= reg_wdata_i[DIV_W-1:0];
        en_q  <= reg_wdata_i[CFG_EN_BIT];
      end
      if (ctrl_wr && ready) begin
        reg_q <= reg_wdata_i[FIELD_W-1:0];
        phy_q <= reg_wdata_i[2*FIELD_W-1:FIELD_W];
        op_q  <= op_in;
      end
      if (reg_we_i && reg_addr_i == ADDR_WDATA)
        wdata_q <= reg_wdata_i[DATA_W-1:0];
      if (rd_valid)
        rdata_q <= rd_data;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CFG: begin
        reg_rdata_o[DIV_W-1:0]  = div_q;
        reg_rdata_o[CFG_EN_BIT] = en_q;
      end
      ADDR_CTRL: begin
        reg_rdata_o[FIELD_W-1:0]         = reg_q;
        reg_rdata_o[2*FIELD_W-1:FIELD_W] = phy_q;
        reg_rdata_o[CTRL_OP_BIT]         = op_q;
        reg_rdata_o[CTRL_RDY_BIT]        = ready;
      end
      ADDR_WDATA: reg_rdata_o[DATA_W-1:0] = wdata_q;
      default:    reg_rdata_o[DATA_W-1:0] = rdata_q;
    endcase
  end

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && en_q),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc),
    .abort_i    (!en_q),
    .op_i       (op_in),
    .phy_i      (reg_wdata_i[2*FIELD_W-1:FIELD_W]),
    .reg_i      (reg_wdata_i[FIELD_W-1:0]),
    .wdata_i    (wdata_q),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  a_r2_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!mdc_o && !mdio_oe_o));
  a_r7_ready_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !ready);
  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !ready) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid |=> $stable(rdata_q));
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  typedef struct {bit rd; logic [4:0] phy; logic [4:0] rg; logic [15:0] d;} item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        phy_drv = 1'b1;
  logic        mdio_i;
  int          n_chk = 0, n_fail = 0, cur_div = 1;
  item_t       exp_q[$];
  event        frame_ev;

  assign mdio_i = mdio_oe_o ? mdio_o : phy_drv;
  always #5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  function automatic logic [31:0] ctrl_word(bit rd, logic [4:0] phy, logic [4:0] rg, bit go);
    return {16'h0, 4'h0, go, rd, phy, rg};
  endfunction

  task automatic wait_ready(output int n);
    n = 0;
    while (!reg_rdata_o[15]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    item_t it;
    int n;
    logic [31:0] v;
    it.rd = rd; it.phy = phy; it.rg = rg; it.d = d;
    exp_q.push_back(it);
    if (!rd) reg_wr(2'd2, {16'h0, d});
    -> frame_ev;
    reg_wr(2'd1, ctrl_word(rd, phy, rg, 1'b1));
    chk(reg_rdata_o[15] == 1'b0, "R7 ready low after start", reg_rdata_o[15], 0);
    wait_ready(n);
    chk(n == 130 * (cur_div + 1), "R7 busy length", n, 130 * (cur_div + 1));
    if (rd) begin
      reg_rd(2'd3, v);
      chk(v == {16'h0, d}, "R6 read data", v, {16'h0, d});
    end
  endtask

  // monitor / PHY responder: pops expected frame and compares
  initial begin
    forever begin
      item_t it;
      logic [63:0] f, o;
      time t1, t2;
      @(frame_ev);
      it = exp_q.pop_front();
      t1 = 0; t2 = 0;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc_o);
        f[63-k] = mdio_o;
        o[63-k] = mdio_oe_o;
        if (k == 1) t1 = $time;
        if (k == 2) t2 = $time;
        if (it.rd && k >= 47 && k < 63) begin
          @(negedge mdc_o);
          phy_drv = it.d[62-k];
        end
      end
      phy_drv = 1'b1;
      chk(f[63:32] == 32'hFFFF_FFFF, "R4 preamble", f[63:32], 32'hFFFF_FFFF);
      chk(f[31:30] == 2'b01, "R4 start code", f[31:30], 2'b01);
      chk(f[29:28] == (it.rd ? 2'b10 : 2'b01), "R4 opcode", f[29:28], it.rd ? 2'b10 : 2'b01);
      chk(f[27:23] == it.phy, "R4 phy address", f[27:23], it.phy);
      chk(f[22:18] == it.rg, "R4 register address", f[22:18], it.rg);
      chk((t2 - t1) == 20 * (cur_div + 1), "R1 mdc period", t2 - t1, 20 * (cur_div + 1));
      if (!it.rd) begin
        chk(f[17:16] == 2'b10, "R5 turnaround", f[17:16], 2'b10);
        chk(f[15:0] == it.d, "R5 write data", f[15:0], it.d);
        chk(&o, "R5 output enable", o[31:0], 32'hFFFF_FFFF);
      end else begin
        chk(o[17:0] == '0, "R6 released", o[17:0], 0);
        chk(&o[63:18], "R6 header driven", o[63:32], 32'hFFFF_FFFF);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    logic [31:0] v;
    bit quiet;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    reg_rd(2'd1, v); chk(v == 32'h8000, "R10 ctrl reset", v, 32'h8000);
    reg_rd(2'd0, v); chk(v == 32'h0, "R10 cfg reset", v, 0);
    reg_rd(2'd3, v); chk(v == 32'h0, "R9 rdata reset", v, 0);
    chk(!mdc_o && !mdio_oe_o, "R10 lines idle", {mdc_o, mdio_oe_o}, 0);

    // R2 start ignored while disabled
    reg_wr(2'd1, ctrl_word(1, 5'd3, 5'd2, 1));
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc_o || mdio_oe_o || !reg_rdata_o[15]) quiet = 0;
    end
    chk(quiet, "R2 disabled start ignored", quiet, 1);

    reg_wr(2'd0, 32'h101);
    xfer(0, 5'd5, 5'h11, 16'hBEEF);
    reg_rd(2'd3, v); chk(v == 32'h0, "R9 rdata kept after write", v, 0);
    xfer(1, 5'h1F, 5'h1F, 16'hA5C3);
    xfer(1, 5'd0, 5'd0, 16'h5A3C);
    xfer(0, 5'h1F, 5'h0A, 16'h0001);
    reg_rd(2'd3, v); chk(v == 32'h5A3C, "R9 rdata kept", v, 32'h5A3C);
    reg_rd(2'd1, v);
    chk(v == (32'h8000 | ctrl_word(0, 5'h1F, 5'h0A, 0)), "R3 ctrl readback", v, 32'h8000 | ctrl_word(0, 5'h1F, 5'h0A, 0));

    // R8 writes while busy, including the completing edge
    begin
      item_t it;
      it.rd = 0; it.phy = 5'd2; it.rg = 5'd3; it.d = 16'h1234;
      exp_q.push_back(it);
      reg_wr(2'd2, 32'h1234);
      -> frame_ev;
      reg_wr(2'd1, ctrl_word(0, 5'd2, 5'd3, 1));
      repeat (50) @(negedge clk);
      reg_wr(2'd1, ctrl_word(1, 5'd9, 5'd9, 1));
      repeat (130 * (cur_div + 1) - 54) @(negedge clk);
      reg_wr(2'd1, ctrl_word(1, 5'd7, 5'd7, 1));
      chk(reg_rdata_o[15] == 1'b1, "R8 completion-edge start rejected", reg_rdata_o[15], 1);
      quiet = 1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (mdc_o || !reg_rdata_o[15]) quiet = 0;
      end
      chk(quiet, "R8 no extra frame", quiet, 1);
      reg_rd(2'd1, v);
      chk(v == (32'h8000 | ctrl_word(0, 5'd2, 5'd3, 0)), "R8 fields kept", v, 32'h8000 | ctrl_word(0, 5'd2, 5'd3, 0));
    end

    // R1 larger divisor
    reg_wr(2'd0, 32'h104);
    cur_div = 4;
    xfer(1, 5'd1, 5'd2, 16'hC0DE);

    // R2 abort by clearing enable
    reg_wr(2'd0, 32'h101);
    cur_div = 1;
    reg_wr(2'd1, ctrl_word(0, 5'd6, 5'd6, 1));
    repeat (40) @(negedge clk);
    reg_wr(2'd0, 32'h001);
    @(negedge clk);
    chk(!mdc_o && !mdio_oe_o, "R2 abort quiets lines", {mdc_o, mdio_oe_o}, 0);
    reg_addr_i = 2'd1;
    #1 chk(reg_rdata_o[15] == 1'b1, "R2 abort ready", reg_rdata_o[15], 1);
    wait_ready(n);
    reg_wr(2'd0, 32'h101);
    xfer(1, 5'd4, 5'd4, 16'h0F0F);
    finish_test();
  end
endmodule